// File: doc/BRIEF.md
# Three-Wire Serial Command Receiver with Streaming Read

This block is the serial front end of a 64-word, 16-bit serial memory. A host drives a select line, a serial clock and a data input. The block samples all of them, including a protect-mode strap, with a faster system clock. It finds a rising serial clock by edge detection. It hunts for a start bit, collects a two-bit opcode and a six-bit address, and decodes one of ten instructions. For the two write-type instructions it then collects a sixteen-bit data word. Every decoded instruction is reported to a companion controller as a one-cycle strobe, together with a code, an address and, for writes, the data. The companion controller checks permissions and owns the program-cycle timing.

Reads are served locally from an internal register file. The companion controller fills that file through a simple write port, one word at a time or all words at once. A memory read drives a zero dummy bit and then streams words back to back for as long as the host keeps clocking, with the address wrapping at the top. A protect-address read returns a dummy bit followed by the six-bit protect address that the companion controller presents. The serial output has its own drive enable, so that a tri-state pad can be built around it.

Top module: `mwCmdReceiver`

## Requirements
- R1: While the receiver is idle, serial-clock rising edges that sample DI = 0 are ignored. The first sampled 1 is the start bit.
- R2: After the start bit, eight more rising edges sample the opcode and then the address, MSB first. Each recognised instruction raises cmdValid for exactly one system-clock cycle. cmdCode and cmdAddr keep their values until the next strobe.
- R3: Decode with opcode 10: READ (cmdCode 1), or PRREAD (cmdCode 6) when preIn is high. Opcode 01: WRITE (2), or PRWRITE (7) when preIn is high. Opcode 11 with an all-ones address and preIn high: PRCLEAR (8).
- R4: Opcode 00 is sub-decoded by the top two address bits. Bits 11 give WEN (4), or PREN (9) with preIn high. Bits 00 give WDS (5), or PRDS (10) with preIn high. Bits 01 with preIn low give WRALL (3).
- R5: WRITE and WRALL collect 16 further data bits, MSB first. Their strobe rises after the last data bit and carries the data on cmdData and the header address on cmdAddr.
- R6: For READ, the edge that samples the last address bit enables DO and drives a 0 dummy bit. The following 16 rising edges drive the addressed word, MSB first.
- R7: Continued clocking during a READ streams the next word immediately, with no dummy bit. The address wraps from word 63 to word 0.
- R8: For PRREAD, a 0 dummy bit is followed by the six protectAddr bits, MSB first, and then by zeros.
- R9: Taking csIn low returns the receiver to the idle state and disables DO. A new instruction decodes normally after csIn rises again.
- R10: doEn stays low while csIn is low, and throughout every instruction other than READ and PRREAD.
- R11: Any other header produces no strobe. This covers opcode 11 without PRE or without an all-ones address, opcode 00 with top bits 10, and opcode 00 with top bits 01 while preIn is high.
- R12: After an instruction completes, further serial-clock edges are ignored until csIn goes low.
- R13: The array write port writes memWData into word memWAddr when memWe is high. With memWrAll also high it writes every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Serial select, active high |
| skIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data in |
| preIn | input | 1 | Protect-mode strap |
| protectAddr | input | 6 | Protect address returned by PRREAD |
| memWe | input | 1 | Array write enable |
| memWrAll | input | 1 | Write every word when memWe is high |
| memWAddr | input | 6 | Array write address |
| memWData | input | 16 | Array write data |
| doOut | output | 1 | Serial data out |
| doEn | output | 1 | Drive enable for doOut |
| cmdValid | output | 1 | One-cycle decoded-instruction strobe |
| cmdCode | output | 4 | Decoded instruction code |
| cmdAddr | output | 6 | Header address field |
| cmdData | output | 16 | Collected data of WRITE or WRALL |

## Verification
The assertions check on every cycle the rules that hold for any traffic. DO is released and no strobe fires once select has been low long enough to pass the synchronizer. The strobe lasts one cycle, and the code changes only with the strobe. Only defined codes are ever strobed, and the output enable always rises on a zero dummy bit. Other behaviour depends on the serial sequence, so only the bench's scenarios can show it. That covers the opcode sub-decode, the bit order of the output stream, the seamless word-to-word continuation and its wrap at word 63, the protect-address readback, and the refusal of malformed headers. The bench's reference model predicts each of these per serial edge.

// File: rtl/mwPkg.sv
package mwPkg;

  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_READ    = 4'd1,
    CMD_WRITE   = 4'd2,
    CMD_WRALL   = 4'd3,
    CMD_WEN     = 4'd4,
    CMD_WDS     = 4'd5,
    CMD_PRREAD  = 4'd6,
    CMD_PRWRITE = 4'd7,
    CMD_PRCLEAR = 4'd8,
    CMD_PREN    = 4'd9,
    CMD_PRDS    = 4'd10
  } cmdCodeE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_READ,
    ST_DONE
  } ctlStateE;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic    clear;      // select low: drop output, flush shifter
    logic    shiftIn;    // capture DI into the input shifter
    logic    latchHdr;   // capture header address for cmdAddr
    logic    loadWord;   // load array word into output shifter
    logic    loadProt;   // load protect address into output shifter
    logic    shiftOut;   // present next output bit
    logic    driveDummy; // enable DO with a zero dummy bit
    logic    emit;       // pulse cmdValid with code
    logic    emitData;   // capture collected data word
    cmdCodeE code;
  } ctlStrobeT;

endpackage

// File: rtl/mwSync.sv
module mwSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  input  logic preIn,
  output logic csOn,
  output logic diBit,
  output logic preBit,
  output logic skRise
);
  localparam int LAST = SYNC_STAGES - 1;

  // bit 3 select, bit 2 serial clock, bit 1 data, bit 0 protect strap
  logic [SYNC_STAGES-1:0][3:0] pipe;
  logic skPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe   <= '0;
      skPrev <= 1'b0;
    end else begin
      pipe[0] <= {csIn, skIn, diIn, preIn};
      for (int s = 1; s < SYNC_STAGES; s++) pipe[s] <= pipe[s-1];
      skPrev <= pipe[LAST][2];
    end
  end

  assign csOn   = pipe[LAST][3];
  assign diBit  = pipe[LAST][1];
  assign preBit = pipe[LAST][0];
  assign skRise = pipe[LAST][2] & ~skPrev;

endmodule

// File: rtl/mwControl.sv
module mwControl
  import mwPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csOn,
  input  logic                 skRise,
  input  logic                 diBit,
  input  logic                 preBit,
  input  logic [ADDR_W+1:0]    hdrNext,
  output ctlStrobeT            strobe
);
  localparam int HDR_W = ADDR_W + 2;
  localparam int MAX_W = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int CNT_W = $clog2(MAX_W + 1);

  ctlStateE         state, nextState;
  logic [CNT_W-1:0] bitCnt, nextCnt;
  cmdCodeE          pendCode, nextPend;
  logic             seqMode, nextSeq;
  cmdCodeE          hdrCode;

  function automatic cmdCodeE decodeHdr(input logic [HDR_W-1:0] h, input logic pre);
    logic [1:0]        op;
    logic [ADDR_W-1:0] a;
    logic [1:0]        sel;
    cmdCodeE           c;
    op  = h[HDR_W-1 -: 2];
    a   = h[ADDR_W-1:0];
    sel = a[ADDR_W-1 -: 2];
    c   = CMD_NONE;
    unique case (op)
      2'b10: c = pre ? CMD_PRREAD : CMD_READ;
      2'b01: c = pre ? CMD_PRWRITE : CMD_WRITE;
      2'b11: c = (pre && (&a)) ? CMD_PRCLEAR : CMD_NONE;
      2'b00: begin
        unique case (sel)
          2'b11:   c = pre ? CMD_PREN : CMD_WEN;
          2'b00:   c = pre ? CMD_PRDS : CMD_WDS;
          2'b01:   c = pre ? CMD_NONE : CMD_WRALL;
          default: c = CMD_NONE;
        endcase
      end
      default: c = CMD_NONE;
    endcase
    return c;
  endfunction

  assign hdrCode = decodeHdr(hdrNext, preBit);

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = bitCnt;
    nextPend  = pendCode;
    nextSeq   = seqMode;
    if (!csOn) begin
      strobe.clear = 1'b1;
      nextState    = ST_IDLE;
      nextCnt      = '0;
    end else if (skRise) begin
      unique case (state)
        ST_IDLE: begin
          if (diBit) begin
            strobe.shiftIn = 1'b1;
            nextState      = ST_HDR;
            nextCnt        = '0;
          end
        end
        ST_HDR: begin
          strobe.shiftIn = 1'b1;
          if (bitCnt == CNT_W'(HDR_W - 1)) begin
            nextCnt = '0;
            unique case (hdrCode)
              CMD_NONE: nextState = ST_DONE;
              CMD_READ, CMD_PRREAD: begin
                strobe.latchHdr   = 1'b1;
                strobe.emit       = 1'b1;
                strobe.code       = hdrCode;
                strobe.driveDummy = 1'b1;
                strobe.loadWord   = (hdrCode == CMD_READ);
                strobe.loadProt   = (hdrCode == CMD_PRREAD);
                nextSeq           = (hdrCode == CMD_READ);
                nextState         = ST_READ;
              end
              CMD_WRITE, CMD_WRALL: begin
                strobe.latchHdr = 1'b1;
                nextPend        = hdrCode;
                nextState       = ST_DATA;
              end
              default: begin
                strobe.latchHdr = 1'b1;
                strobe.emit     = 1'b1;
                strobe.code     = hdrCode;
                nextState       = ST_DONE;
              end
            endcase
          end else begin
            nextCnt = bitCnt + 1'b1;
          end
        end
        ST_DATA: begin
          strobe.shiftIn = 1'b1;
          if (bitCnt == CNT_W'(DATA_W - 1)) begin
            strobe.emit     = 1'b1;
            strobe.emitData = 1'b1;
            strobe.code     = pendCode;
            nextState       = ST_DONE;
            nextCnt         = '0;
          end else begin
            nextCnt = bitCnt + 1'b1;
          end
        end
        ST_READ: begin
          strobe.shiftOut = 1'b1;
          if (seqMode) begin
            if (bitCnt == CNT_W'(DATA_W - 1)) begin
              strobe.loadWord = 1'b1;
              nextCnt         = '0;
            end else begin
              nextCnt = bitCnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      pendCode <= CMD_NONE;
      seqMode  <= 1'b0;
    end else begin
      state    <= nextState;
      bitCnt   <= nextCnt;
      pendCode <= nextPend;
      seqMode  <= nextSeq;
    end
  end

endmodule

// File: rtl/mwDatapath.sv
module mwDatapath
  import mwPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobe,
  input  logic              diBit,
  input  logic [ADDR_W-1:0] protectAddr,
  input  logic              memWe,
  input  logic              memWrAll,
  input  logic [ADDR_W-1:0] memWAddr,
  input  logic [DATA_W-1:0] memWData,
  output logic [ADDR_W+1:0] hdrNext,
  output logic              doOut,
  output logic              doEn,
  output logic              cmdValid,
  output logic [3:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);
  localparam int HDR_W = ADDR_W + 2;
  localparam int IN_W  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int WORDS = 1 << ADDR_W;

  logic [IN_W-1:0]               inShift, shiftNext;
  logic [DATA_W-1:0]             outShift;
  logic [ADDR_W-1:0]             rdPtr, rdAddr, hdrAddr;
  logic [DATA_W-1:0]             rdWord;
  logic [WORDS-1:0][DATA_W-1:0]  mem;
  logic [WORDS-1:0]              wordWe;

  assign shiftNext = {inShift[IN_W-2:0], diBit};
  assign hdrNext   = shiftNext[HDR_W-1:0];
  assign hdrAddr   = hdrNext[ADDR_W-1:0];

  // register file: one write enable per word
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign wordWe[w] = memWe & (memWrAll | (memWAddr == ADDR_W'(w)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mem <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (wordWe[w]) mem[w] <= memWData;
      end
    end
  end

  assign rdAddr = strobe.latchHdr ? hdrAddr : rdPtr;
  assign rdWord = mem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      outShift <= '0;
      rdPtr    <= '0;
      doOut    <= 1'b0;
      doEn     <= 1'b0;
      cmdValid <= 1'b0;
      cmdCode  <= 4'd0;
      cmdAddr  <= '0;
      cmdData  <= '0;
    end else begin
      cmdValid <= 1'b0;
      if (strobe.clear) begin
        inShift <= '0;
        doOut   <= 1'b0;
        doEn    <= 1'b0;
      end else begin
        if (strobe.shiftIn)  inShift <= shiftNext;
        if (strobe.latchHdr) cmdAddr <= hdrAddr;
        if (strobe.emit) begin
          cmdValid <= 1'b1;
          cmdCode  <= strobe.code;
        end
        if (strobe.emitData) cmdData <= shiftNext[DATA_W-1:0];
        if (strobe.driveDummy) begin
          doEn  <= 1'b1;
          doOut <= 1'b0;
        end
        if (strobe.shiftOut) begin
          doOut    <= outShift[DATA_W-1];
          outShift <= outShift << 1;
        end
        if (strobe.loadProt) outShift <= DATA_W'(protectAddr) << (DATA_W - ADDR_W);
        if (strobe.loadWord) begin
          outShift <= rdWord;
          rdPtr    <= rdAddr + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mwCmdReceiver.sv
module mwCmdReceiver
  import mwPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              skIn,
  input  logic              diIn,
  input  logic              preIn,
  input  logic [ADDR_W-1:0] protectAddr,
  input  logic              memWe,
  input  logic              memWrAll,
  input  logic [ADDR_W-1:0] memWAddr,
  input  logic [DATA_W-1:0] memWData,
  output logic              doOut,
  output logic              doEn,
  output logic              cmdValid,
  output logic [3:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);
  logic              csOn, diBit, preBit, skRise;
  logic [ADDR_W+1:0] hdrNext;
  ctlStrobeT         strobe;

  mwSync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN),
    .csIn(csIn), .skIn(skIn), .diIn(diIn), .preIn(preIn),
    .csOn(csOn), .diBit(diBit), .preBit(preBit), .skRise(skRise)
  );

  mwControl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_control (
    .clk(clk), .rstN(rstN),
    .csOn(csOn), .skRise(skRise), .diBit(diBit), .preBit(preBit),
    .hdrNext(hdrNext), .strobe(strobe)
  );

  mwDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .diBit(diBit),
    .protectAddr(protectAddr),
    .memWe(memWe), .memWrAll(memWrAll), .memWAddr(memWAddr), .memWData(memWData),
    .hdrNext(hdrNext), .doOut(doOut), .doEn(doEn),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

endmodule

// File: rtl/mwCmdReceiverChk.sv
module mwCmdReceiverChk (
  input logic       clk,
  input logic       rstN,
  input logic       csIn,
  input logic       doEn,
  input logic       doOut,
  input logic       cmdValid,
  input logic [3:0] cmdCode
);
  // consecutive cycles with select low, saturating
  logic [2:0] csLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csLowCnt <= '0;
    else if (csIn) csLowCnt <= '0;
    else if (csLowCnt != 3'd7) csLowCnt <= csLowCnt + 3'd1;
  end

  // R10: output released once select low has crossed the synchronizer
  p_doen_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csLowCnt >= 3'd4) |-> !doEn);

  // R9: no instruction is reported while the receiver is held in reset by select
  p_nocmd_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csLowCnt >= 3'd4) |-> !cmdValid);

  // R2: strobe lasts a single cycle
  p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R2: the code changes only together with the strobe
  p_code_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdCode) |-> cmdValid);

  // R11: only defined codes are strobed
  p_code_legal_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdCode >= 4'd1 && cmdCode <= 4'd10));

  // R6: the drive enable always rises on a zero dummy bit
  p_dummy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doEn) |-> !doOut);

endmodule

bind mwCmdReceiver mwCmdReceiverChk i_chk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .doEn(doEn), .doOut(doOut),
  .cmdValid(cmdValid), .cmdCode(cmdCode)
);

// File: tb/test_mwCmdReceiver.sv
`timescale 1ns/1ps
module test_mwCmdReceiver;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csIn = 1'b0, skIn = 1'b0, diIn = 1'b0, preIn = 1'b0;
  logic [5:0]  protectAddr = 6'h2D;
  logic        memWe = 1'b0, memWrAll = 1'b0;
  logic [5:0]  memWAddr = '0;
  logic [15:0] memWData = '0;
  logic        doOut, doEn, cmdValid;
  logic [3:0]  cmdCode;
  logic [5:0]  cmdAddr;
  logic [15:0] cmdData;

  always #10 clk = ~clk;

  mwCmdReceiver i_mwCmdReceiver (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn), .preIn(preIn),
    .protectAddr(protectAddr), .memWe(memWe), .memWrAll(memWrAll),
    .memWAddr(memWAddr), .memWData(memWData),
    .doOut(doOut), .doEn(doEn), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int memM [64];
  int mSt = 0, mCnt = 0, mHdr = 0, mData = 0, mPend = 0, mPtr = 0, mPos = 0, mSeq = 0;
  int expDoEn = 0, expDo = 0;
  int expCnt = 0, expCode = 0, expAddr = 0, expData = 0;

  // observed strobes
  int         seenCnt = 0;
  logic [3:0] seenCode = '0;
  logic [5:0] seenAddr = '0;
  logic [15:0] seenData = '0;

  always @(posedge clk) begin
    if (rstN && cmdValid) begin
      seenCnt++;
      seenCode = cmdCode;
      seenAddr = cmdAddr;
      seenData = cmdData;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int decodeM(input int op, input int a, input int pre);
    int t = a >> 4;
    case (op)
      2: return pre ? 6 : 1;
      1: return pre ? 7 : 2;
      3: return (pre && a == 63) ? 8 : 0;
      default: begin
        if (t == 3) return pre ? 9 : 4;
        if (t == 0) return pre ? 10 : 5;
        if (t == 1) return pre ? 0 : 3;
        return 0;
      end
    endcase
  endfunction

  task automatic modelReset();
    mSt = 0; mCnt = 0; expDoEn = 0; expDo = 0;
  endtask

  task automatic modelEdge(input int di);
    int code;
    case (mSt)
      0: if (di != 0) begin mSt = 1; mCnt = 0; mHdr = 0; end
      1: begin
        mHdr = mHdr * 2 + di;
        mCnt++;
        if (mCnt == 8) begin
          code = decodeM((mHdr >> 6) & 3, mHdr & 63, int'(preIn));
          if (code == 0) mSt = 4;
          else if (code == 2 || code == 3) begin
            mPend = code; mAddr_set(mHdr & 63); mSt = 2; mCnt = 0; mData = 0;
          end else begin
            expCnt++; expCode = code; expAddr = mHdr & 63;
            if (code == 1 || code == 6) begin
              expDoEn = 1; expDo = 0; mSt = 3;
              mSeq = (code == 1);
              mPtr = mHdr & 63;
              mPos = (code == 1) ? 15 : 5;
            end else mSt = 4;
          end
        end
      end
      2: begin
        mData = ((mData << 1) | di) & 16'hFFFF;
        mCnt++;
        if (mCnt == 16) begin
          expCnt++; expCode = mPend; expData = mData; mSt = 4;
        end
      end
      3: begin
        if (mSeq != 0) begin
          expDo = (memM[mPtr] >> mPos) & 1;
          if (mPos == 0) begin mPos = 15; mPtr = (mPtr + 1) % 64; end
          else mPos--;
        end else begin
          if (mPos >= 0) begin expDo = (int'(protectAddr) >> mPos) & 1; mPos--; end
          else expDo = 0;
        end
      end
      default: ;
    endcase
  endtask

  int pendAddr = 0;
  task automatic mAddr_set(input int a);
    pendAddr = a; expAddr = a;
  endtask

  // one serial clock period: 4 system clocks low, 4 high; compare after the rise
  task automatic skCycle(input bit di, input string req);
    skIn = 1'b0; diIn = di;
    repeat (4) @(negedge clk);
    skIn = 1'b1;
    modelEdge(int'(di));
    repeat (4) @(negedge clk);
    chk(doEn == expDoEn[0], {req, " doEn"}, int'(doEn), expDoEn);
    if (expDoEn != 0) chk(doOut == expDo[0], {req, " doOut"}, int'(doOut), expDo);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) skCycle(v[i], req);
  endtask

  task automatic csHigh(input bit pre);
    preIn = pre; skIn = 1'b0; csIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic csLow(input string req);
    skIn = 1'b0; csIn = 1'b0;
    repeat (6) @(negedge clk);
    modelReset();
    chk(doEn == 1'b0, {req, " doEn after select low"}, int'(doEn), 0);
  endtask

  task automatic cmdChk(input string req, input bit withData);
    chk(seenCnt == expCnt, {req, " strobe count"}, seenCnt, expCnt);
    if (expCnt > 0) begin
      chk(int'(seenCode) == expCode, {req, " code"}, int'(seenCode), expCode);
      chk(int'(seenAddr) == expAddr, {req, " addr"}, int'(seenAddr), expAddr);
      if (withData) chk(int'(seenData) == expData, {req, " data"}, int'(seenData), expData);
    end
  endtask

  task automatic instr(input bit pre, input logic [31:0] v, input int n, input string req, input bit withData);
    csHigh(pre);
    sendBits(v, n, req);
    cmdChk(req, withData);
    csLow(req);
  endtask

  task automatic memWrite(input bit all, input int a, input int d);
    memWe = 1'b1; memWrAll = all; memWAddr = 6'(a); memWData = 16'(d);
    @(negedge clk);
    memWe = 1'b0; memWrAll = 1'b0;
    for (int i = 0; i < 64; i++) if (all || i == a) memM[i] = d & 16'hFFFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) memM[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(doEn == 1'b0, "R10 reset doEn", int'(doEn), 0);
    chk(cmdValid == 1'b0, "R2 reset cmdValid", int'(cmdValid), 0);

    // R13: single-word writes through the array port
    for (int i = 0; i < 64; i++) memWrite(1'b0, i, ((i * 16'h0939) ^ 16'h5A3C) & 16'hFFFF);

    // R1 R6 R3: leading zeros, then READ of word 5 with one full word
    csHigh(1'b0);
    sendBits({20'd0, 3'b000, 1'b1, 2'b10, 6'd5}, 12, "R1 R6 READ");
    cmdChk("R3 READ", 1'b0);
    for (int k = 0; k < 16; k++) skCycle(1'b0, "R6 READ word");
    csLow("R9 READ");

    // R7: streaming across the top of the array
    csHigh(1'b0);
    sendBits({23'd0, 1'b1, 2'b10, 6'd62}, 9, "R7 READ");
    for (int k = 0; k < 52; k++) skCycle(1'b0, "R7 stream wrap");
    csLow("R7 READ");

    // R8: protect-address readback
    csHigh(1'b1);
    sendBits({23'd0, 1'b1, 2'b10, 6'd17}, 9, "R8 PRREAD");
    cmdChk("R3 PRREAD", 1'b0);
    for (int k = 0; k < 10; k++) skCycle(1'b1, "R8 PRREAD bits");
    csLow("R8 PRREAD");

    // R5 R10: WRITE and WRALL with data
    instr(1'b0, {7'd0, 1'b1, 2'b01, 6'd9, 16'hBEEF}, 25, "R5 R10 WRITE", 1'b1);
    instr(1'b0, {7'd0, 1'b1, 2'b00, 6'b01_0000, 16'h1234}, 25, "R4 R5 WRALL", 1'b1);

    // R3 R4: remaining decodes
    instr(1'b0, {23'd0, 1'b1, 2'b00, 6'b11_0000}, 9, "R4 WEN", 1'b0);
    instr(1'b1, {23'd0, 1'b1, 2'b00, 6'b11_0101}, 9, "R4 PREN", 1'b0);
    instr(1'b0, {23'd0, 1'b1, 2'b00, 6'b00_1010}, 9, "R4 WDS", 1'b0);
    instr(1'b1, {23'd0, 1'b1, 2'b00, 6'b00_0000}, 9, "R4 PRDS", 1'b0);
    instr(1'b1, {23'd0, 1'b1, 2'b01, 6'd42}, 9, "R3 PRWRITE", 1'b0);
    instr(1'b1, {23'd0, 1'b1, 2'b11, 6'd63}, 9, "R3 PRCLEAR", 1'b0);

    // R11: headers that must not produce a strobe
    instr(1'b0, {23'd0, 1'b1, 2'b11, 6'd63}, 9, "R11 op11 no PRE", 1'b0);
    instr(1'b1, {23'd0, 1'b1, 2'b11, 6'd62}, 9, "R11 op11 partial", 1'b0);
    instr(1'b0, {23'd0, 1'b1, 2'b00, 6'b10_0000}, 9, "R11 op00 sel10", 1'b0);
    instr(1'b1, {23'd0, 1'b1, 2'b00, 6'b01_0000, 16'hFFFF}, 25, "R11 WRALL with PRE", 1'b0);

    // R12: extra clocking after a finished instruction
    csHigh(1'b0);
    sendBits({23'd0, 1'b1, 2'b00, 6'b11_0000}, 9, "R12 WEN");
    sendBits({23'd0, 1'b1, 2'b01, 6'd3}, 9, "R12 trailing");
    cmdChk("R12 no second strobe", 1'b0);
    csLow("R12");

    // R9: select dropped mid-header, then a fresh instruction
    csHigh(1'b0);
    sendBits({27'd0, 1'b1, 2'b10, 2'b00}, 5, "R9 partial");
    csLow("R9 partial");
    instr(1'b0, {23'd0, 1'b1, 2'b00, 6'b00_0000}, 9, "R9 fresh WDS", 1'b0);

    // R9: select dropped in the middle of a read stream
    csHigh(1'b0);
    sendBits({23'd0, 1'b1, 2'b10, 6'd20}, 9, "R9 READ");
    for (int k = 0; k < 5; k++) skCycle(1'b0, "R9 READ bits");
    csLow("R9 mid-read");

    // R13: write-all through the array port, then stream it back
    memWrite(1'b1, 0, 16'h6C93);
    csHigh(1'b0);
    sendBits({23'd0, 1'b1, 2'b10, 6'd63}, 9, "R13 READ");
    for (int k = 0; k < 32; k++) skCycle(1'b0, "R13 all words");
    csLow("R13");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule